// File: doc/BRIEF.md
# Page Write Buffer Controller

This block gathers the data bytes of one memory write transaction into a small page buffer and later commits them to a nonvolatile array in a single timed write cycle. At the start of a transaction it latches a byte address. The upper bits become the page base. The low five bits seed an in-page pointer. Each byte that arrives is placed at the pointer's position, and only the pointer advances, wrapping inside the 32-byte page. Before each byte is accepted, a separate protect controller is asked whether the current address may be written. Its answer decides whether the byte is kept.

Nothing is written to the array while bytes arrive. A stop pulse starts the commit, but only if at least one position was loaded. The block then raises `busy` for a fixed number of clock cycles. During the first 32 of those cycles it walks the page positions in order and issues a one-cycle memory write for each loaded position. While `busy` is high, every input from the transaction side is ignored.

Top module: `pwb_page_ctrl`

## Requirements
- R1: After reset, `busy` and `mem_we` are low and no page position is loaded.
- R2: A `txn_start` pulse while idle latches the page base (`start_addr` bits ADDR_W-1..5) and the pointer (bits 4..0). It also discards previously loaded positions. `prot_addr` always equals {base, pointer}.
- R3: Each `byte_vld` pulse while idle (and without `txn_start`) advances the pointer by one modulo 32, and the page base stays unchanged.
- R4: When more than 32 bytes arrive before a stop, the pointer wraps, and the last byte sent to a position is the one committed there.
- R5: A byte strobed while `prot_ok` is low is not buffered, but the pointer still advances.
- R6: `mem_we` stays low while bytes are collected; writes begin only after a stop.
- R7: A `stop` while idle, with at least one loaded position, raises `busy` on the next cycle. `busy` then stays high for exactly WRITE_CYCLES cycles.
- R8: In busy cycle i (i = 0 for the first cycle), for i < 32, `mem_we` pulses if and only if position i is loaded, with `mem_addr` = {base, i} and `mem_wdata` = the buffered byte.
- R9: Committed positions are cleared, so a second stop without new bytes writes nothing and does not raise `busy`.
- R10: A stop with no loaded position leaves `busy` low and issues no write.
- R11: While `busy` is high, `txn_start`, `byte_vld` and `stop` have no effect on the base, the pointer, the buffer or the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | Start of a write transaction; latches start_addr |
| start_addr | input | ADDR_W | Full byte address of the transaction |
| byte_vld | input | 1 | One-cycle strobe for a received data byte |
| byte_data | input | DATA_W | Data byte |
| stop | input | 1 | Stop pulse that requests the commit |
| prot_addr | output | ADDR_W | Address of the next byte, presented to the protect controller |
| prot_ok | input | 1 | Protect controller allows a write at prot_addr |
| busy | output | 1 | Write cycle in progress; inputs ignored |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
If the pointer is corrupted, `prot_addr` is wrong already on the next byte. If a valid bit or a buffered byte is corrupted, the error shows during the commit: the write for that position is missing, extra, or carries the wrong data, in exactly the busy cycle that matches the position. A timer fault shows up as a `busy` length other than WRITE_CYCLES. A leak from the inputs while busy shows up as a moved `prot_addr`, or as an unexpected write on the following stop.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int PTR_W      = 5;
  localparam int PAGE_BYTES = 1 << PTR_W;
  typedef logic [PTR_W-1:0] pos_t;
endpackage

// File: rtl/pwb_addr_track.sv
module pwb_addr_track
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              start_acc_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_acc_i,
  output logic [ADDR_W-PTR_W-1:0] base_o,
  output pos_t              ptr_o
);
  localparam int BASE_W = ADDR_W - PTR_W;

  logic [BASE_W-1:0] base_q, base_d;
  pos_t              ptr_q, ptr_d;

  always_comb begin
    base_d = base_q;
    ptr_d  = ptr_q;
    if (start_acc_i) begin
      base_d = start_addr_i[ADDR_W-1:PTR_W];
      ptr_d  = start_addr_i[PTR_W-1:0];
    end else if (byte_acc_i) begin
      ptr_d  = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else begin
      base_q <= base_d;
      ptr_q  <= ptr_d;
    end
  end

  assign base_o = base_q;
  assign ptr_o  = ptr_q;

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_acc_i |=> (ptr_q == $past(ptr_q) + 1'b1) && $stable(base_q));
  // R11
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(base_q) && $stable(ptr_q));
endmodule

// File: rtl/pwb_page_store.sv
module pwb_page_store
  import pwb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  pos_t              wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_all_i,
  input  logic              clr_en_i,
  input  pos_t              clr_idx_i,
  input  pos_t              rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              any_vld_o
);
  logic [DATA_W-1:0]     dat_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q, vld_d;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_entry
    logic hit_wr;
    assign hit_wr = wr_en_i && (wr_idx_i == pos_t'(g));
    always_ff @(posedge clk) begin
      if (hit_wr) dat_q[g] <= wr_data_i;
    end
    always_comb begin
      vld_d[g] = vld_q[g];
      if (clr_all_i) vld_d[g] = 1'b0;
      else if (hit_wr) vld_d[g] = 1'b1;
      else if (clr_en_i && clr_idx_i == pos_t'(g)) vld_d[g] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign rd_data_o = dat_q[rd_idx_i];
  assign rd_vld_o  = vld_q[rd_idx_i];
  assign any_vld_o = |vld_q;

  // R9
  clr_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en_i && !wr_en_i && !clr_all_i |=> !vld_q[$past(clr_idx_i)]);
  // R2
  start_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> (vld_q == '0));
endmodule

// File: rtl/pwb_commit_seq.sv
module pwb_commit_seq
  import pwb_pkg::*;
#(
  parameter int WRITE_CYCLES = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_i,
  input  logic any_vld_i,
  input  logic pos_vld_i,
  output logic busy_o,
  output pos_t scan_idx_o,
  output logic we_o
);
  localparam int TMR_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [TMR_W-1:0] LAST = TMR_W'(WRITE_CYCLES - 1);
  localparam logic [TMR_W-1:0] SCAN = TMR_W'(PAGE_BYTES);

  logic             busy_q, busy_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             in_scan;

  always_comb begin
    busy_d = busy_q;
    tmr_d  = tmr_q;
    if (!busy_q) begin
      if (stop_i && any_vld_i) begin
        busy_d = 1'b1;
        tmr_d  = '0;
      end
    end else if (tmr_q == LAST) begin
      busy_d = 1'b0;
      tmr_d  = '0;
    end else begin
      tmr_d  = tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tmr_q  <= '0;
    end else begin
      busy_q <= busy_d;
      tmr_q  <= tmr_d;
    end
  end

  assign in_scan    = busy_q && (tmr_q < SCAN);
  assign scan_idx_o = tmr_q[PTR_W-1:0];
  assign we_o       = in_scan && pos_vld_i;
  assign busy_o     = busy_q;

  // R7
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(stop_i && any_vld_i) && (tmr_q == '0));
  // R10
  empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && !any_vld_i |=> !busy_q);
  // R8
  scan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (tmr_q != LAST) |=> busy_q && (tmr_q == $past(tmr_q) + 1'b1));
  // R6
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> busy_q && $past(busy_q || stop_i));
endmodule

// File: rtl/pwb_page_ctrl.sv
module pwb_page_ctrl
  import pwb_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop,
  output logic [ADDR_W-1:0] prot_addr,
  input  logic              prot_ok,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int BASE_W = ADDR_W - PTR_W;

  logic              busy_w, start_acc, byte_acc, stop_acc, we_w;
  logic              any_vld, pos_vld;
  logic [BASE_W-1:0] base;
  pos_t              ptr, scan_idx;
  logic [DATA_W-1:0] rd_data;

  assign start_acc = txn_start && !busy_w;
  assign byte_acc  = byte_vld && !txn_start && !busy_w;
  assign stop_acc  = stop && !busy_w;

  pwb_addr_track #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_w),
    .start_acc_i(start_acc), .start_addr_i(start_addr),
    .byte_acc_i(byte_acc), .base_o(base), .ptr_o(ptr));

  pwb_page_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(byte_acc && prot_ok), .wr_idx_i(ptr), .wr_data_i(byte_data),
    .clr_all_i(start_acc), .clr_en_i(we_w), .clr_idx_i(scan_idx),
    .rd_idx_i(scan_idx), .rd_data_o(rd_data), .rd_vld_o(pos_vld),
    .any_vld_o(any_vld));

  pwb_commit_seq #(.WRITE_CYCLES(WRITE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_acc), .any_vld_i(any_vld),
    .pos_vld_i(pos_vld), .busy_o(busy_w), .scan_idx_o(scan_idx), .we_o(we_w));

  assign prot_addr = {base, ptr};
  assign busy      = busy_w;
  assign mem_we    = we_w;
  assign mem_addr  = {base, scan_idx};
  assign mem_wdata = rd_data;

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !busy && !mem_we);
  // R8
  commit_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mem_addr[ADDR_W-1:PTR_W]));
endmodule

// File: tb/pwb_page_ctrl_bench.sv
module pwb_page_ctrl_bench;
  localparam int AW = 12, DW = 8, WC = 48, PG = 32;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          txn_start = 0, byte_vld = 0, stop = 0, prot_ok = 1;
  logic [AW-1:0] start_addr = '0;
  logic [DW-1:0] byte_data = '0;
  logic [AW-1:0] prot_addr, mem_addr;
  logic          busy, mem_we;
  logic [DW-1:0] mem_wdata;

  always #5 clk = ~clk;

  pwb_page_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WRITE_CYCLES(WC)) u_pwb_page_ctrl (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .start_addr(start_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop(stop),
    .prot_addr(prot_addr), .prot_ok(prot_ok), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [AW-6:0] m_base;
  logic [4:0]    m_ptr;
  logic [DW-1:0] m_dat [PG];
  bit            m_vld [PG];

  function automatic logic [AW-1:0] exp_addr(logic [AW-6:0] b, logic [4:0] p);
    return {b, p};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic begin_txn(logic [AW-1:0] a);
    @(negedge clk);
    txn_start = 1; start_addr = a;
    @(negedge clk);
    txn_start = 0;
    m_base = a[AW-1:5]; m_ptr = a[4:0];
    for (int k = 0; k < PG; k++) m_vld[k] = 0;
    chk("R2 prot_addr", 32'(prot_addr), 32'(exp_addr(m_base, m_ptr)));
  endtask

  task automatic send_byte(logic [DW-1:0] d, logic ok);
    @(negedge clk);
    chk("R3 prot_addr", 32'(prot_addr), 32'(exp_addr(m_base, m_ptr)));
    chk("R6 no write", 32'({busy, mem_we}), 32'(0));
    byte_vld = 1; byte_data = d; prot_ok = ok;
    @(negedge clk);
    byte_vld = 0; prot_ok = 1;
    if (ok) begin m_dat[m_ptr] = d; m_vld[m_ptr] = 1; end
    m_ptr = m_ptr + 1'b1;
  endtask

  task automatic commit(bit inject);
    bit nonempty = 0;
    for (int k = 0; k < PG; k++) if (m_vld[k]) nonempty = 1;
    @(negedge clk);
    stop = 1;
    for (int j = 0; j < WC + 4; j++) begin
      @(negedge clk);
      stop = 0; txn_start = 0; byte_vld = 0;
      chk("R7 busy", 32'(busy), 32'(nonempty && j < WC));
      if (j < PG && nonempty) begin
        chk("R8 we", 32'(mem_we), 32'(m_vld[j]));
        if (mem_we && m_vld[j]) begin
          chk("R8 addr", 32'(mem_addr), 32'(exp_addr(m_base, 5'(j))));
          chk("R8 data", 32'(mem_wdata), 32'(m_dat[j]));
        end
      end else begin
        chk("R10 no write", 32'(mem_we), 32'(0));
      end
      if (inject && j == 5) begin
        txn_start = 1; byte_vld = 1; stop = 1;
        start_addr = AW'($urandom); byte_data = 8'hEE;
      end
    end
    for (int k = 0; k < PG; k++) m_vld[k] = 0;
    chk("R11 prot_addr", 32'(prot_addr), 32'(exp_addr(m_base, m_ptr)));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 busy", 32'(busy), 32'(0));
    chk("R1 we", 32'(mem_we), 32'(0));
    rst_n = 1;
    // R1: nothing loaded: a stop right after reset starts nothing
    m_base = '0; m_ptr = '0;
    for (int k = 0; k < PG; k++) m_vld[k] = 0;
    commit(0);
    // R3: start near page end, wrap of the pointer inside the page
    begin_txn(12'h3FC);
    for (int k = 0; k < 6; k++) send_byte(8'h10 + 8'(k), 1);
    commit(0);
    // R9: second stop with nothing new
    commit(0);
    // R10: empty transaction
    begin_txn(12'hA40);
    commit(0);
    // R4: 40 bytes overwrite the first 8 positions
    begin_txn(12'h560);
    for (int k = 0; k < 40; k++) send_byte(8'($urandom), 1);
    commit(0);
    // R5: denied bytes skipped, pointer still moves
    begin_txn(12'h7E5);
    for (int k = 0; k < 10; k++) send_byte(8'($urandom), k[0]);
    commit(0);
    // R11: inputs while busy ignored; injected byte must not appear later
    begin_txn(12'h123);
    for (int k = 0; k < 3; k++) send_byte(8'($urandom), 1);
    commit(1);
    commit(0);
    // R2: restart discards loaded bytes
    begin_txn(12'h200);
    send_byte(8'h55, 1);
    begin_txn(12'h300);
    send_byte(8'h66, 1);
    commit(0);
    // random mix
    for (int t = 0; t < 12; t++) begin
      int nb = int'($urandom_range(0, 40));
      begin_txn(AW'($urandom));
      for (int k = 0; k < nb; k++) send_byte(8'($urandom), ($urandom_range(0, 3) != 0));
      commit(t[1:0] == 2'd3);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule